// File: doc/BRIEF.md
# Host Data Transfer Engine

This block drains a byte buffer toward a host once a transfer has been armed. Software loads a 16-bit byte count and a 16-bit data address, then pulses a trigger that carries a 3-bit destination code. For the two host-read codes, the engine raises a data-ready flag. Each host read strobe then returns one big-endian 16-bit word taken from the buffer, moves the address forward by two and takes two off the byte count.

When the count, read as a signed 16-bit number, drops to zero or below, the transfer ends. The count is reloaded with 0xF000. The active-low busy and data-enable flags return high. Data-ready clears and an end-of-transfer flag is set. An interrupt request is raised when both enables allow it.

The three DMA destination codes are only reported through a one-cycle select pulse, because the memory writes are handled elsewhere. Every other code arms nothing.

The buffer is external. The engine drives an even byte address on `buf_addr`, and the buffer returns the byte at that address on `buf_hi` and the byte at the next address on `buf_lo`, both within the same cycle.

Top module: `hdx_engine`

## Requirements
- R1: After reset, busy_n=1, dten_n=1, dsr=0, edt=0, irq=0, dma_sel=0, dest=0, count=0, addr=0 and rd_valid=0.
- R2: A trigger sets busy_n to 0, clears count bits 15:12, clears edt and latches trig_dest into dest, all visible one cycle later.
- R3: A trigger with destination code 2 or 3 sets dten_n to 0 and dsr to 1. dsr is never 1 while dten_n is 1.
- R4: A trigger with code 4, 5 or 7 pulses dma_sel for exactly one cycle and leaves dten_n=1 and dsr=0. Codes 0, 1 and 6 pulse nothing and leave dten_n=1 and dsr=0.
- R5: A host read (hrd high for one cycle) while dten_n=0 gives rd_valid=1 and rd_data={byte at (addr & 0x3FFE), byte at (addr & 0x3FFE)+1} in the next cycle.
- R6: Each host read while dten_n=0 adds 2 to addr and subtracts 2 from count (both modulo 2^16).
- R7: When count minus 2, as a signed 16-bit value, is zero or negative at a host read, the next cycle shows count=0xF000, busy_n=1, dten_n=1, dsr=0, edt=1 and the same dest.
- R8: irq goes to 1 at a transfer end only when xfer_ie and lvl_ie are both 1. It then stays 1 until a cycle with irq_ack high.
- R9: A host read while dten_n=1 returns rd_data=0 with rd_valid=1 and changes neither count nor addr.
- R10: ld_count and ld_addr load ld_data into count and addr when no trigger and no active host read occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Transfer trigger pulse |
| trig_dest | input | 3 | Destination code sampled with trig |
| ld_count | input | 1 | Load byte count from ld_data |
| ld_addr | input | 1 | Load data address from ld_data |
| ld_data | input | 16 | Load value |
| hrd | input | 1 | Host read strobe |
| buf_addr | output | 14 | Even buffer byte address |
| buf_hi | input | 8 | Buffer byte at buf_addr |
| buf_lo | input | 8 | Buffer byte at buf_addr+1 |
| rd_data | output | 16 | Word returned by the last host read |
| rd_valid | output | 1 | rd_data updated this cycle |
| xfer_ie | input | 1 | Transfer-end interrupt enable |
| lvl_ie | input | 1 | Interrupt level enable |
| irq_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Level interrupt request |
| busy_n | output | 1 | Busy flag, active low |
| dten_n | output | 1 | Data-enable flag, active low |
| dsr | output | 1 | Data ready |
| edt | output | 1 | End of transfer |
| dest | output | 3 | Latched destination code |
| dma_sel | output | 1 | One-cycle pulse: DMA destination chosen |
| count | output | 16 | Byte count |
| addr | output | 16 | Data address |

## Verification
The assertions check several rules on every cycle. A trigger arms the flags. A read steps the counters by two. A read at the signed end reloads 0xF000 and flips every flag. An idle read leaves the counters alone. The interrupt can only rise with both enables set and it holds until acknowledged. The bench scenarios cover what a cycle-local rule cannot. These include the exact word order built from the buffer bytes and masking of the upper address bits. They also include multi-read transfers that start from odd, zero and near-0x8000 counts, the clearing of the count's top nibble by a trigger, and the interplay between loads, retriggers and acknowledges over long random runs.

// File: rtl/hdx_pkg.sv
// Shared types for the host data transfer engine.
// Assumes destination codes are 3 bits wide.
package hdx_pkg;

    typedef enum logic [1:0] {
        DK_NONE = 2'd0,
        DK_HOST = 2'd1,
        DK_DMA  = 2'd2
    } dest_kind_t;

    // Classify a destination code into host-read, DMA or invalid.
    function automatic dest_kind_t classify(input logic [2:0] code);
        case (code)
            3'd2, 3'd3:       return DK_HOST;
            3'd4, 3'd5, 3'd7: return DK_DMA;
            default:          return DK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hdx_counters.sv
// Byte count and data address registers.
// A trigger clears the top bits of the count. An active read steps both
// counters, and a read at the signed end reloads the count.
// Assumes trig and rd_go are never high together (the top gates rd_go).
module hdx_counters #(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 16,
    parameter int STEP     = 2,
    parameter int CLR_BITS = 4,
    parameter logic [CNT_W-1:0] RELOAD = 16'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              rd_go,
    input  logic              ld_count,
    input  logic              ld_addr,
    input  logic [CNT_W-1:0]  ld_data,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] addr,
    output logic              fin
);
    localparam int KEEP_W = CNT_W - CLR_BITS;

    logic [CNT_W-1:0] cnt_dec;

    // Next count after one read, and the signed end-of-transfer test on it.
    always_comb begin
        cnt_dec = count - CNT_W'(STEP);
        fin     = cnt_dec[CNT_W-1] || (cnt_dec == '0);
    end

    // Byte count register: trigger clears the top bits, reads count down, loads write it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (trig)
            count <= {{CLR_BITS{1'b0}}, count[KEEP_W-1:0]};
        else if (rd_go)
            count <= fin ? RELOAD : cnt_dec;
        else if (ld_count)
            count <= ld_data;
    end

    // Data address register: reads step it forward, loads write it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (rd_go)
            addr <= addr + ADDR_W'(STEP);
        else if (ld_addr && !trig)
            addr <= ADDR_W'(ld_data);
    end

endmodule

// File: rtl/hdx_ctrl.sv
// Status flags, destination latch, DMA select pulse and interrupt request.
// Assumes rd_go is only high when data-enable is active and no trigger is present.
module hdx_ctrl
    import hdx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic [2:0] trig_dest,
    input  logic       rd_go,
    input  logic       fin,
    input  logic       xfer_ie,
    input  logic       lvl_ie,
    input  logic       irq_ack,
    output logic       busy_n,
    output logic       dten_n,
    output logic       dsr,
    output logic       edt,
    output logic [2:0] dest,
    output logic       dma_sel,
    output logic       irq
);
    dest_kind_t kind;
    logic       ending;

    // Decode the incoming code and detect the last read of a transfer.
    always_comb begin
        kind   = classify(trig_dest);
        ending = rd_go && fin;
    end

    // Flags and destination: armed by a trigger, released at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_n <= 1'b1;
            dten_n <= 1'b1;
            dsr    <= 1'b0;
            edt    <= 1'b0;
            dest   <= '0;
        end else if (trig) begin
            busy_n <= 1'b0;
            dten_n <= (kind != DK_HOST);
            dsr    <= (kind == DK_HOST);
            edt    <= 1'b0;
            dest   <= trig_dest;
        end else if (ending) begin
            busy_n <= 1'b1;
            dten_n <= 1'b1;
            dsr    <= 1'b0;
            edt    <= 1'b1;
        end
    end

    // One-cycle report that a DMA destination was chosen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_sel <= 1'b0;
        else
            dma_sel <= trig && (kind == DK_DMA);
    end

    // Level interrupt: set on a gated transfer end, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (ending && xfer_ie && lvl_ie)
            irq <= 1'b1;
        else if (irq_ack)
            irq <= 1'b0;
    end

endmodule

// File: rtl/hdx_readpath.sv
// Host read path: forms the even buffer address and registers the returned word.
// Assumes the external buffer answers within the same cycle.
module hdx_readpath #(
    parameter int ADDR_W = 16,
    parameter int BUF_AW = 14,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hrd,
    input  logic                rd_go,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   buf_hi,
    input  logic [BYTE_W-1:0]   buf_lo,
    output logic [BUF_AW-1:0]   buf_addr,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic                rd_valid
);
    // Force the buffer address even and drop the bits above the buffer size.
    always_comb buf_addr = {addr[BUF_AW-1:1], 1'b0};

    // Capture the big-endian word on an active read, or zero on an idle one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= hrd;
            if (hrd)
                rd_data <= rd_go ? {buf_hi, buf_lo} : '0;
        end
    end

endmodule

// File: rtl/hdx_engine.sv
// Top of the host data transfer engine.
// Priority within a cycle: trigger, then host read, then loads.
// A host read in the same cycle as a trigger is answered with zero.
module hdx_engine #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16,
    parameter int BUF_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [2:0]        trig_dest,
    input  logic              ld_count,
    input  logic              ld_addr,
    input  logic [CNT_W-1:0]  ld_data,
    input  logic              hrd,
    output logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_hi,
    input  logic [7:0]        buf_lo,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    input  logic              xfer_ie,
    input  logic              lvl_ie,
    input  logic              irq_ack,
    output logic              irq,
    output logic              busy_n,
    output logic              dten_n,
    output logic              dsr,
    output logic              edt,
    output logic [2:0]        dest,
    output logic              dma_sel,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] addr
);
    logic rd_go;
    logic fin;

    // A read moves data only while data-enable is active and no trigger competes.
    always_comb rd_go = hrd && !dten_n && !trig;

    hdx_counters #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .rd_go    (rd_go),
        .ld_count (ld_count),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .count    (count),
        .addr     (addr),
        .fin      (fin)
    );

    hdx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_dest (trig_dest),
        .rd_go     (rd_go),
        .fin       (fin),
        .xfer_ie   (xfer_ie),
        .lvl_ie    (lvl_ie),
        .irq_ack   (irq_ack),
        .busy_n    (busy_n),
        .dten_n    (dten_n),
        .dsr       (dsr),
        .edt       (edt),
        .dest      (dest),
        .dma_sel   (dma_sel),
        .irq       (irq)
    );

    hdx_readpath #(
        .ADDR_W (ADDR_W),
        .BUF_AW (BUF_AW)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .hrd      (hrd),
        .rd_go    (rd_go),
        .addr     (addr),
        .buf_hi   (buf_hi),
        .buf_lo   (buf_lo),
        .buf_addr (buf_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/hdx_engine_chk.sv
// Protocol checker for hdx_engine, attached through bind.
module hdx_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trig,
    input logic [2:0]  trig_dest,
    input logic        ld_count,
    input logic        ld_addr,
    input logic        hrd,
    input logic [15:0] rd_data,
    input logic        xfer_ie,
    input logic        lvl_ie,
    input logic        irq_ack,
    input logic        irq,
    input logic        busy_n,
    input logic        dten_n,
    input logic        dsr,
    input logic        edt,
    input logic        dma_sel,
    input logic [15:0] count,
    input logic [15:0] addr
);
    AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (!busy_n && !edt && count[15:12] == 4'h0)); // R2

    AST_HOST_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (trig_dest == 3'd2 || trig_dest == 3'd3)) |=> (!dten_n && dsr)); // R3

    AST_DSR_NEEDS_DTEN: assert property (@(posedge clk) disable iff (!rst_n)
        dsr |-> !dten_n); // R3

    AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (trig_dest == 3'd4 || trig_dest == 3'd5 || trig_dest == 3'd7)) |=> (dma_sel && dten_n)); // R4

    AST_DMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_sel && !trig) |=> !dma_sel); // R4

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hrd && !dten_n && !trig && $signed(count - 16'd2) > 0)
        |=> (addr == $past(addr) + 16'd2 && count == $past(count) - 16'd2)); // R6

    AST_END_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hrd && !dten_n && !trig && $signed(count - 16'd2) <= 0)
        |=> (count == 16'hF000 && busy_n && dten_n && edt && !dsr)); // R7

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (hrd && dten_n && !trig && !ld_count && !ld_addr)
        |=> ($stable(count) && $stable(addr) && rd_data == 16'h0000)); // R9

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(xfer_ie && lvl_ie) && edt)); // R8

endmodule

bind hdx_engine hdx_engine_chk u_chk (.*);

// File: tb/hdx_engine_tb.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared every cycle against a model written from the requirements.
module hdx_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [2:0]  trig_dest = '0;
    logic        ld_count = 1'b0;
    logic        ld_addr = 1'b0;
    logic [15:0] ld_data = '0;
    logic        hrd = 1'b0;
    logic [13:0] buf_addr;
    logic [7:0]  buf_hi;
    logic [7:0]  buf_lo;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        xfer_ie = 1'b0;
    logic        lvl_ie = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq;
    logic        busy_n, dten_n, dsr, edt, dma_sel;
    logic [2:0]  dest;
    logic [15:0] count, addr;

    int n_chk = 0;
    int n_fail = 0;

    // Expected state.
    logic        m_busy_n, m_dten_n, m_dsr, m_edt, m_dma, m_irq, m_rv;
    logic [2:0]  m_dest;
    logic [15:0] m_cnt, m_addr, m_rd;

    always #2 clk = ~clk;

    hdx_engine u_dut (.*);

    function automatic logic [7:0] buf_byte(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b01} ^ 8'h5A;
    endfunction

    // Buffer model: answers combinationally.
    always_comb begin
        buf_hi = buf_byte(buf_addr);
        buf_lo = buf_byte(buf_addr + 14'd1);
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic compare_all();
        chk("R2 R7 busy_n", 16'(busy_n), 16'(m_busy_n));
        chk("R3 R7 dten_n", 16'(dten_n), 16'(m_dten_n));
        chk("R3 R7 dsr",    16'(dsr),    16'(m_dsr));
        chk("R2 R7 edt",    16'(edt),    16'(m_edt));
        chk("R2 dest",      16'(dest),   16'(m_dest));
        chk("R4 dma_sel",   16'(dma_sel), 16'(m_dma));
        chk("R6 R10 count", count, m_cnt);
        chk("R6 R10 addr",  addr,  m_addr);
        chk("R8 irq",       16'(irq),    16'(m_irq));
        chk("R5 R9 rd_valid", 16'(rd_valid), 16'(m_rv));
        chk("R5 R9 rd_data",  rd_data, m_rd);
    endtask

    // Expected effect of the inputs held across one rising edge.
    task automatic model_edge();
        logic [13:0] ba;
        logic        ends;
        ends  = 1'b0;
        m_dma = 1'b0;
        m_rv  = hrd;
        if (trig) begin
            m_busy_n = 1'b0;
            m_cnt    = {4'h0, m_cnt[11:0]};
            m_edt    = 1'b0;
            m_dest   = trig_dest;
            m_dten_n = !(trig_dest == 3'd2 || trig_dest == 3'd3);
            m_dsr    = !m_dten_n;
            m_dma    = (trig_dest == 3'd4 || trig_dest == 3'd5 || trig_dest == 3'd7);
            if (hrd) m_rd = 16'h0000;
        end else if (hrd && !m_dten_n) begin
            ba     = m_addr[13:0] & 14'h3FFE;
            m_rd   = {buf_byte(ba), buf_byte(ba + 14'd1)};
            m_addr = m_addr + 16'd2;
            m_cnt  = m_cnt - 16'd2;
            if ($signed(m_cnt) <= 0) begin
                ends     = 1'b1;
                m_cnt    = 16'hF000;
                m_busy_n = 1'b1;
                m_dten_n = 1'b1;
                m_dsr    = 1'b0;
                m_edt    = 1'b1;
            end
        end else begin
            if (hrd) m_rd = 16'h0000;
            if (ld_count) m_cnt = ld_data;
            if (ld_addr) m_addr = ld_data;
        end
        if (ends && xfer_ie && lvl_ie) m_irq = 1'b1;
        else if (irq_ack) m_irq = 1'b0;
    endtask

    // One cycle: drive after the falling edge, model the rising edge, compare at the next falling edge.
    task automatic step(input logic t, input logic [2:0] d, input logic lc, input logic la,
                        input logic [15:0] v, input logic h, input logic ak);
        trig = t; trig_dest = d; ld_count = lc; ld_addr = la; ld_data = v; hrd = h; irq_ack = ak;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        trig = 1'b0; ld_count = 1'b0; ld_addr = 1'b0; hrd = 1'b0; irq_ack = 1'b0;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        m_busy_n = 1'b1; m_dten_n = 1'b1; m_dsr = 1'b0; m_edt = 1'b0; m_dma = 1'b0;
        m_irq = 1'b0; m_rv = 1'b0; m_dest = '0; m_cnt = '0; m_addr = '0; m_rd = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        compare_all();

        // R5, R7, R8: one-read transfer, upper address bits masked, gated irq set.
        xfer_ie = 1'b1; lvl_ie = 1'b1;
        step(0, 0, 1, 0, 16'h0001, 0, 0);
        step(0, 0, 0, 1, 16'h4005, 0, 0);
        step(1, 3'd3, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        // R9: idle read after the end returns zero; irq held until ack (R8).
        step(0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        // R8: end with interrupt disabled raises nothing; count 0 ends at once (R7).
        lvl_ie = 1'b0;
        step(0, 0, 1, 0, 16'h0000, 0, 0);
        step(1, 3'd2, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        lvl_ie = 1'b1;
        // R4: DMA and invalid codes.
        step(1, 3'd5, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        step(1, 3'd6, 0, 0, 0, 0, 0);
        step(1, 3'd7, 0, 0, 0, 0, 0);
        // R2: trigger clears the top nibble, then three reads finish it (R6).
        step(0, 0, 1, 0, 16'hF006, 0, 0);
        step(1, 3'd2, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1);

        // Seeded random traffic, one operation per cycle.
        for (int i = 0; i < 6000; i++) begin
            int op;
            logic [15:0] v;
            op = $urandom_range(0, 15);
            if ($urandom_range(0, 40) == 0) xfer_ie = $urandom_range(0, 1);
            if ($urandom_range(0, 40) == 0) lvl_ie = $urandom_range(0, 1);
            case ($urandom_range(0, 3))
                0: v = 16'h8000 | 16'($urandom_range(0, 8));
                1: v = 16'h7FFE + 16'($urandom_range(0, 3));
                default: v = 16'($urandom_range(0, 24));
            endcase
            if (op == 0)
                step(1, ($urandom_range(0, 1) != 0) ? 3'($urandom_range(2, 3)) : 3'($urandom_range(0, 7)),
                     0, 0, 0, 0, 0);
            else if (op == 1)
                step(0, 0, 1, 0, v, 0, 0);
            else if (op == 2)
                step(0, 0, 0, 1, 16'($urandom()), 0, 0);
            else if (op == 3)
                step(0, 0, 0, 0, 0, 0, 1);
            else if (op <= 12)
                step(0, 0, 0, 0, 0, 1, 0);
            else
                step(0, 0, 0, 0, 0, 0, 0);
        end
        finish_run();
    end

endmodule